// File: doc/BRIEF.md
# SPI Message Transfer Sequencer

This block walks a byte-wide SPI master engine through one message at a time. A message is a chain of transfers. Each transfer descriptor arrives on a valid/ready port and gives a byte count, whether transmit bytes come from the tx stream, whether received bytes go to the rx stream, a post-transfer delay in clock cycles, a flag asking for chip select to drop after the transfer, and a flag marking the final transfer. The first descriptor of a message also carries the SPI mode bits and the ratio of bus clock to target SCK rate. The sequencer turns that ratio into an exponent/prescaler pair for the engine.

The engine tells the sequencer about each byte through three event strobes: byte complete (with the received byte), write collision and mode fault. The sequencer retries a collided byte, aborts the message on a mode fault, and drives chip select. At the end of each message it raises a one-cycle completion pulse with an error flag. Four saturating counters track completed messages, completed bytes, collisions and mode faults.

States: `ST_IDLE` waits for a descriptor. `ST_XFER` writes bytes and consumes engine events. `ST_WAIT` runs the post-transfer delay and then chains to the next transfer. Transitions: IDLE→XFER on accepting a descriptor. XFER→WAIT when the final byte of a transfer completes. XFER→IDLE on a mode fault. WAIT→XFER on accepting the next descriptor of the message. WAIT→IDLE once the delay of the final transfer has run out.

Top module: `spi_msg_seq`

## Requirements
- R1: After reset `cs_n` is 1, `msg_done`, `msg_err`, `eng_wr`, `rx_valid` and `spurious` are 0, all four counters are 0, and `desc_ready` is 1.
- R2: In idle, an accepted descriptor latches `desc_cpol`/`desc_cpha`/`desc_lsb_first` onto the engine mode outputs, drives `cs_n` low, and writes the first byte on the next cycle. That byte is the head of the tx stream when `desc_has_tx` is 1 and 0x00 otherwise. No byte is written while `cs_n` is high.
- R3: For a clock ratio `r`, the sequencer starts from s = max(1, floor((r+1)/2)) and e = 0. While s−1 > 7 it sets s = floor((s+1)/2) and e = e+1. It then outputs `eng_prescale` = s−1 and `eng_exponent` = e, and both are 7 if e > 7. Examples: 2→(0,0), 16→(7,0), 20→(4,1), 100→(6,3), 1000→(7,6), 4000→(7,7).
- R4: Each byte-complete event taken while a byte is in flight decrements the remaining length. If `desc_rx_en` was 1 it produces one `rx_valid` pulse on the next cycle carrying `evt_rdata`. If bytes remain, the next byte is written.
- R5: A write-collision event rewrites the previous byte in the same cycle (0x00 for a transfer with no tx data) and leaves the remaining length unchanged. Collision has priority over mode fault, and mode fault has priority over byte complete.
- R6: A mode-fault event raises `cs_n` and pulses `msg_done` with `msg_err` = 1 on the next cycle, and the sequencer returns to idle.
- R7: After the final byte of a transfer with delay d, the sequencer stays in wait for d cycles. For the final transfer of a message, `msg_done` and `cs_n` rise on the edge d+1 cycles after the edge that captured the final byte-complete event.
- R8: When the final transfer completes, `cs_n` goes to 1 and `msg_done` pulses with `msg_err` = 0.
- R9: Between transfers of one message, `cs_n` goes high for at least one cycle only when the finished transfer had `desc_cs_change` = 1. Otherwise it stays low. It goes low again when the next descriptor is accepted.
- R10: An engine event that arrives in idle, in wait, or in transfer with no byte in flight produces a one-cycle `spurious` pulse on the next cycle and changes no other output or counter.
- R11: `cnt_msgs` counts messages that end with success, `cnt_bytes` counts byte-complete events taken, `cnt_wcol` counts collisions taken and `cnt_modf` counts mode faults taken. Each counter holds at its all-ones value.
- R12: `msg_done` lasts one cycle, and `msg_err` changes only on a cycle where `msg_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_len | input | LEN_W | Byte count of the transfer |
| desc_has_tx | input | 1 | Transmit bytes come from the tx stream |
| desc_rx_en | input | 1 | Received bytes go to the rx stream |
| desc_delay | input | DLY_W | Post-transfer delay in clock cycles |
| desc_cs_change | input | 1 | Drop chip select after this transfer |
| desc_last | input | 1 | Final transfer of the message |
| desc_cpol | input | 1 | Clock polarity for the message |
| desc_cpha | input | 1 | Clock phase for the message |
| desc_lsb_first | input | 1 | Bit order for the message |
| desc_ratio | input | RATIO_W | Bus clock to target SCK ratio |
| tx_valid | input | 1 | Tx byte valid |
| tx_ready | output | 1 | Tx byte consumed |
| tx_data | input | 8 | Tx byte |
| rx_valid | output | 1 | Rx byte strobe |
| rx_data | output | 8 | Rx byte |
| eng_cpol | output | 1 | Engine clock polarity |
| eng_cpha | output | 1 | Engine clock phase |
| eng_lsb_first | output | 1 | Engine bit order |
| eng_prescale | output | 3 | Engine baud prescaler |
| eng_exponent | output | 3 | Engine baud exponent |
| eng_wr | output | 1 | Write strobe into the engine data register |
| eng_wdata | output | 8 | Byte to shift out |
| evt_done | input | 1 | Engine byte complete |
| evt_wcol | input | 1 | Engine write collision |
| evt_modf | input | 1 | Engine mode fault |
| evt_rdata | input | 8 | Byte received by the engine |
| cs_n | output | 1 | Active-low chip select |
| msg_done | output | 1 | Message finished pulse |
| msg_err | output | 1 | 1 if the last message aborted on a mode fault |
| spurious | output | 1 | Unexpected engine event pulse |
| cnt_msgs | output | CNT_W | Successful message count |
| cnt_bytes | output | CNT_W | Completed byte count |
| cnt_wcol | output | CNT_W | Collision count |
| cnt_modf | output | CNT_W | Mode fault count |

## Verification
A wrong remaining-length count shows up within one byte time. Either an extra byte or a missing byte is written to the engine, and the rx stream runs out of step with the bytes the bench expects. A wrong state or a lost in-flight flag shows up at the next engine event as a `spurious` pulse, a retry of the wrong byte, or chip select moving at the wrong time. A mistake in the delay timer or the final-transfer decode moves the `msg_done` edge away from d+1 cycles after the last byte, so it is seen when the message ends.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic has_tx;
        logic rx_en;
        logic cs_change;
        logic last;
    } xfer_flags_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_mode_t;

    localparam int NUM_CNT  = 4;
    localparam int CNT_MSG  = 0;
    localparam int CNT_BYTE = 1;
    localparam int CNT_WCOL = 2;
    localparam int CNT_MODF = 3;

endpackage

// File: rtl/spi_seq_baud.sv
module spi_seq_baud #(
    parameter int RATIO_W = 16
) (
    input  logic [RATIO_W-1:0] ratio,
    output logic [2:0]         prescale,
    output logic [2:0]         exponent
);
    localparam int SW = RATIO_W + 1;

    logic [SW-1:0] s;
    logic [7:0]    e;

    always_comb begin
        s = ({1'b0, ratio} + SW'(1)) >> 1;
        if (s == '0) begin
            s = SW'(1);
        end
        e = '0;
        for (int i = 0; i < RATIO_W; i++) begin
            if ((s - SW'(1)) > SW'(7)) begin
                s = (s + SW'(1)) >> 1;
                e = e + 8'd1;
            end
        end
        if (e > 8'd7) begin
            prescale = 3'd7;
            exponent = 3'd7;
        end else begin
            prescale = 3'(s - SW'(1));
            exponent = e[2:0];
        end
    end

endmodule

// File: rtl/spi_seq_satcnt.sv
module spi_seq_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    logic [DLY_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - DLY_W'(1);
        end
    end

    assign expired = (remain_q == '0);
endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
    import spi_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int DLY_W   = 8,
    parameter int RATIO_W = 16,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [LEN_W-1:0]   desc_len,
    input  logic               desc_has_tx,
    input  logic               desc_rx_en,
    input  logic [DLY_W-1:0]   desc_delay,
    input  logic               desc_cs_change,
    input  logic               desc_last,
    input  logic               desc_cpol,
    input  logic               desc_cpha,
    input  logic               desc_lsb_first,
    input  logic [RATIO_W-1:0] desc_ratio,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [7:0]         tx_data,
    output logic               rx_valid,
    output logic [7:0]         rx_data,
    output logic               eng_cpol,
    output logic               eng_cpha,
    output logic               eng_lsb_first,
    output logic [2:0]         eng_prescale,
    output logic [2:0]         eng_exponent,
    output logic               eng_wr,
    output logic [7:0]         eng_wdata,
    input  logic               evt_done,
    input  logic               evt_wcol,
    input  logic               evt_modf,
    input  logic [7:0]         evt_rdata,
    output logic               cs_n,
    output logic               msg_done,
    output logic               msg_err,
    output logic               spurious,
    output logic [CNT_W-1:0]   cnt_msgs,
    output logic [CNT_W-1:0]   cnt_bytes,
    output logic [CNT_W-1:0]   cnt_wcol,
    output logic [CNT_W-1:0]   cnt_modf
);
    seq_state_e  state_q, state_d;
    xfer_flags_t flags_q;
    spi_mode_t   mode_q;
    logic [2:0]  pre_q, exp_q, pre_calc, exp_calc;
    logic [LEN_W-1:0] rem_q;
    logic [DLY_W-1:0] dly_q;
    logic [7:0]  last_tx_q, rx_d_q;
    logic        need_q, cs_n_q, done_q, err_q, rx_v_q, spur_q;

    logic in_flight, byte_avail, last_byte;
    logic take_wcol, take_modf, take_done, spur_now;
    logic send_new, accept, wait_ok, finish_ok, drop_cs, tmr_load, tmr_expired;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    spi_seq_baud #(.RATIO_W(RATIO_W)) u_baud (
        .ratio    (desc_ratio),
        .prescale (pre_calc),
        .exponent (exp_calc)
    );

    spi_seq_timer #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dly_q),
        .expired  (tmr_expired)
    );

    // Event qualification and strobes
    always_comb begin
        in_flight  = (state_q == ST_XFER) && !need_q;
        byte_avail = !flags_q.has_tx || tx_valid;
        last_byte  = (rem_q == LEN_W'(1));
        take_wcol  = in_flight && evt_wcol;
        take_modf  = in_flight && !evt_wcol && evt_modf;
        take_done  = in_flight && !evt_wcol && !evt_modf && evt_done;
        spur_now   = (evt_done || evt_wcol || evt_modf) && !in_flight;
        send_new   = (state_q == ST_XFER) && need_q && byte_avail;
        wait_ok    = (state_q == ST_WAIT) && tmr_expired && !flags_q.last
                     && !(flags_q.cs_change && !cs_n_q);
        drop_cs    = (state_q == ST_WAIT) && tmr_expired && !flags_q.last
                     && flags_q.cs_change && !cs_n_q;
        finish_ok  = (state_q == ST_WAIT) && tmr_expired && flags_q.last;
        desc_ready = (state_q == ST_IDLE) || wait_ok;
        accept     = desc_valid && desc_ready;
        tmr_load   = take_done && last_byte;
        eng_wr     = send_new || take_wcol;
        eng_wdata  = take_wcol ? last_tx_q : (flags_q.has_tx ? tx_data : 8'h00);
        tx_ready   = send_new && flags_q.has_tx;
        cnt_inc[CNT_MSG]  = finish_ok;
        cnt_inc[CNT_BYTE] = take_done;
        cnt_inc[CNT_WCOL] = take_wcol;
        cnt_inc[CNT_MODF] = take_modf;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_XFER;
            ST_XFER: begin
                if (take_modf) begin
                    state_d = ST_IDLE;
                end else if (take_done && last_byte) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (finish_ok) begin
                    state_d = ST_IDLE;
                end else if (accept) begin
                    state_d = ST_XFER;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            mode_q    <= '0;
            pre_q     <= '0;
            exp_q     <= '0;
            rem_q     <= '0;
            dly_q     <= '0;
            last_tx_q <= '0;
            rx_d_q    <= '0;
            need_q    <= 1'b0;
            cs_n_q    <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rx_v_q    <= 1'b0;
            spur_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rx_v_q <= 1'b0;
            spur_q <= spur_now;
            if (accept) begin
                flags_q <= '{has_tx: desc_has_tx, rx_en: desc_rx_en,
                             cs_change: desc_cs_change, last: desc_last};
                rem_q   <= (desc_len == '0) ? LEN_W'(1) : desc_len;
                dly_q   <= desc_delay;
                need_q  <= 1'b1;
                cs_n_q  <= 1'b0;
                if (state_q == ST_IDLE) begin
                    mode_q <= '{cpol: desc_cpol, cpha: desc_cpha, lsb_first: desc_lsb_first};
                    pre_q  <= pre_calc;
                    exp_q  <= exp_calc;
                end
            end
            if (send_new) begin
                need_q    <= 1'b0;
                last_tx_q <= eng_wdata;
            end
            if (take_done) begin
                rem_q  <= rem_q - LEN_W'(1);
                need_q <= !last_byte;
                rx_v_q <= flags_q.rx_en;
                rx_d_q <= evt_rdata;
            end
            if (take_modf) begin
                cs_n_q <= 1'b1;
                done_q <= 1'b1;
                err_q  <= 1'b1;
            end
            if (finish_ok) begin
                cs_n_q <= 1'b1;
                done_q <= 1'b1;
                err_q  <= 1'b0;
            end
            if (drop_cs) begin
                cs_n_q <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        spi_seq_satcnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    assign cnt_msgs      = cnt_val[CNT_MSG];
    assign cnt_bytes     = cnt_val[CNT_BYTE];
    assign cnt_wcol      = cnt_val[CNT_WCOL];
    assign cnt_modf      = cnt_val[CNT_MODF];
    assign cs_n          = cs_n_q;
    assign msg_done      = done_q;
    assign msg_err       = err_q;
    assign rx_valid      = rx_v_q;
    assign rx_data       = rx_d_q;
    assign spurious      = spur_q;
    assign eng_cpol      = mode_q.cpol;
    assign eng_cpha      = mode_q.cpha;
    assign eng_lsb_first = mode_q.lsb_first;
    assign eng_prescale  = pre_q;
    assign eng_exponent  = exp_q;

endmodule

// File: rtl/spi_msg_seq_chk.sv
module spi_msg_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             msg_done,
    input logic             msg_err,
    input logic             eng_wr,
    input logic             rx_valid,
    input logic             evt_done,
    input logic [CNT_W-1:0] cnt_bytes
);
    // R8
    done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |-> cs_n);

    // R2
    wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wr |-> !cs_n);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> !msg_done);

    // R12
    status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_done |-> $stable(msg_err));

    // R4
    rx_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(evt_done));

    // R11
    bytes_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_bytes >= $past(cnt_bytes));
endmodule

bind spi_msg_seq spi_msg_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .msg_done  (msg_done),
    .msg_err   (msg_err),
    .eng_wr    (eng_wr),
    .rx_valid  (rx_valid),
    .evt_done  (evt_done),
    .cnt_bytes (cnt_bytes)
);

// File: tb/spi_msg_seq_tb_top.sv
module spi_msg_seq_tb_top;
    localparam int LEN_W = 8, DLY_W = 8, RATIO_W = 16, CNT_W = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic desc_valid, desc_ready, desc_has_tx, desc_rx_en, desc_cs_change, desc_last;
    logic desc_cpol, desc_cpha, desc_lsb_first;
    logic [LEN_W-1:0] desc_len;
    logic [DLY_W-1:0] desc_delay;
    logic [RATIO_W-1:0] desc_ratio;
    logic tx_valid, tx_ready, rx_valid;
    logic [7:0] tx_data, rx_data, eng_wdata, evt_rdata;
    logic eng_cpol, eng_cpha, eng_lsb_first, eng_wr;
    logic [2:0] eng_prescale, eng_exponent;
    logic evt_done, evt_wcol, evt_modf;
    logic cs_n, msg_done, msg_err, spurious;
    logic [CNT_W-1:0] cnt_msgs, cnt_bytes, cnt_wcol, cnt_modf;

    spi_msg_seq #(.LEN_W(LEN_W), .DLY_W(DLY_W), .RATIO_W(RATIO_W), .CNT_W(CNT_W)) dut_i (.*);

    typedef struct {
        int len; int dly; int ratio;
        bit has_tx, rx_en, csc, last, cpol, cpha, lsb;
    } desc_t;
    typedef struct {
        bit err; int diff; int pre; int ex; bit cpol, cpha, lsb;
    } stat_t;

    desc_t desc_q[$];
    logic [7:0] tx_q[$], exp_wr_q[$], exp_rx_q[$];
    stat_t stat_q[$];

    int checks = 0, fails = 0, cyc = 0;
    int msgs_seen = 0, spur_seen = 0, cs_rises = 0, done_evts = 0, last_evt_cyc = 0;
    int wr_idx = 0, wcol_at = -1, modf_at = -1;
    bit spur_req = 0, retry_pend = 0, d_fire = 0, t_fire = 0, cs_prev = 1;
    logic [7:0] last_wr = 8'h00;

    bit m_cpol, m_cpha, m_lsb; int m_ratio, m_pre, m_exp, m_csc, m_rise0;
    logic [7:0] seed;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // watchdog
    initial begin
        wait (cyc > 50000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
        finish_run();
    end

    // descriptor feeder
    initial begin
        desc_valid = 0; desc_len = '0; desc_has_tx = 0; desc_rx_en = 0; desc_delay = '0;
        desc_cs_change = 0; desc_last = 0; desc_cpol = 0; desc_cpha = 0; desc_lsb_first = 0;
        desc_ratio = '0;
        forever begin
            @(negedge clk);
            if (d_fire) void'(desc_q.pop_front());
            if (desc_q.size() > 0) begin
                desc_valid = 1;
                desc_len = LEN_W'(desc_q[0].len);
                desc_delay = DLY_W'(desc_q[0].dly);
                desc_ratio = RATIO_W'(desc_q[0].ratio);
                desc_has_tx = desc_q[0].has_tx; desc_rx_en = desc_q[0].rx_en;
                desc_cs_change = desc_q[0].csc; desc_last = desc_q[0].last;
                desc_cpol = desc_q[0].cpol; desc_cpha = desc_q[0].cpha;
                desc_lsb_first = desc_q[0].lsb;
            end else begin
                desc_valid = 0;
            end
            #1 d_fire = desc_valid && desc_ready;
        end
    end

    // tx stream feeder
    initial begin
        tx_valid = 0; tx_data = '0;
        forever begin
            @(negedge clk);
            if (t_fire) void'(tx_q.pop_front());
            tx_valid = (tx_q.size() > 0);
            tx_data = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
            #1 t_fire = tx_valid && tx_ready;
        end
    end

    // engine model: checks written bytes, answers after a fixed latency
    initial begin
        int resp = 0, resp_idx = 0;
        logic [7:0] e;
        evt_done = 0; evt_wcol = 0; evt_modf = 0; evt_rdata = '0;
        forever begin
            @(negedge clk);
            evt_done = 0; evt_wcol = 0; evt_modf = 0;
            if (spur_req) begin
                evt_done = 1; evt_rdata = 8'h3C; spur_req = 0;
            end else if (resp > 0) begin
                resp--;
                if (resp == 0) begin
                    if (resp_idx == wcol_at) begin
                        evt_wcol = 1; retry_pend = 1;
                    end else if (resp_idx == modf_at) begin
                        evt_modf = 1; last_evt_cyc = cyc;
                    end else begin
                        evt_done = 1; evt_rdata = last_wr ^ 8'hA5;
                        done_evts++; last_evt_cyc = cyc;
                    end
                end
            end
            #2;
            if (eng_wr && rst_n) begin
                if (retry_pend) begin
                    chk(eng_wdata == last_wr, "R5 retry byte", eng_wdata, last_wr);
                    retry_pend = 0;
                end else if (exp_wr_q.size() == 0) begin
                    chk(0, "R4 unexpected write", eng_wdata, 0);
                end else begin
                    e = exp_wr_q.pop_front();
                    chk(eng_wdata == e, "R4 written byte", eng_wdata, e);
                end
                last_wr = eng_wdata; resp_idx = wr_idx; wr_idx++; resp = 3;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        stat_t s;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                if (rx_valid) begin
                    if (exp_rx_q.size() == 0) chk(0, "R4 unexpected rx", rx_data, 0);
                    else begin
                        e = exp_rx_q.pop_front();
                        chk(rx_data == e, "R4 rx byte", rx_data, e);
                    end
                end
                if (spurious) spur_seen++;
                if (cs_n && !cs_prev) cs_rises++;
                cs_prev = cs_n;
                if (msg_done) begin
                    msgs_seen++;
                    if (stat_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
                    else begin
                        s = stat_q.pop_front();
                        chk(msg_err == s.err, s.err ? "R6 status" : "R8 status", msg_err, s.err);
                        chk(cyc - last_evt_cyc == s.diff, s.err ? "R6 timing" : "R7 delay",
                            cyc - last_evt_cyc, s.diff);
                        chk(eng_prescale == 3'(s.pre), "R3 prescale", eng_prescale, s.pre);
                        chk(eng_exponent == 3'(s.ex), "R3 exponent", eng_exponent, s.ex);
                        chk({eng_cpol, eng_cpha, eng_lsb_first} == {s.cpol, s.cpha, s.lsb},
                            "R2 mode", {eng_cpol, eng_cpha, eng_lsb_first}, {s.cpol, s.cpha, s.lsb});
                    end
                end
            end
        end
    end

    task automatic msg_begin(input bit cpol, input bit cpha, input bit lsb,
                             input int ratio, input int pre, input int ex);
        m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_ratio = ratio;
        m_pre = pre; m_exp = ex; m_csc = 0; m_rise0 = cs_rises;
    endtask

    task automatic xfer(input int len, input bit has_tx, input bit rx_en, input int dly,
                        input bit csc, input bit last, input bit will_fault);
        desc_t d;
        logic [7:0] b;
        for (int i = 0; i < len; i++) begin
            b = has_tx ? seed : 8'h00;
            if (has_tx) begin tx_q.push_back(seed); seed = seed + 8'd7; end
            exp_wr_q.push_back(b);
            if (rx_en && !(will_fault && i == len - 1)) exp_rx_q.push_back(b ^ 8'hA5);
        end
        if (csc && !last) m_csc++;
        d.len = len; d.dly = dly; d.ratio = m_ratio; d.has_tx = has_tx; d.rx_en = rx_en;
        d.csc = csc; d.last = last; d.cpol = m_cpol; d.cpha = m_cpha; d.lsb = m_lsb;
        desc_q.push_back(d);
    endtask

    task automatic msg_end(input bit err, input int diff);
        stat_t s;
        int n0;
        s.err = err; s.diff = diff; s.pre = m_pre; s.ex = m_exp;
        s.cpol = m_cpol; s.cpha = m_cpha; s.lsb = m_lsb;
        n0 = msgs_seen;
        stat_q.push_back(s);
        while (msgs_seen == n0) @(negedge clk);
        repeat (5) @(negedge clk);
        #3;
        chk(msg_done == 0 && msg_err == err, "R12 status held", msg_err, err);
        chk(cs_rises - m_rise0 == 1 + m_csc, "R9 cs drops", cs_rises - m_rise0, 1 + m_csc);
    endtask

    initial begin
        seed = 8'h11;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #3;
        chk(cs_n == 1, "R1 cs_n", cs_n, 1);
        chk({msg_done, msg_err, eng_wr, rx_valid, spurious} == 5'b0, "R1 strobes",
            {msg_done, msg_err, eng_wr, rx_valid, spurious}, 0);
        chk({cnt_msgs, cnt_bytes, cnt_wcol, cnt_modf} == '0, "R1 counters",
            {cnt_msgs, cnt_bytes, cnt_wcol, cnt_modf}, 0);
        chk(desc_ready == 1, "R1 desc_ready", desc_ready, 1);

        // A: single transfer with tx and rx
        msg_begin(1, 0, 1, 20, 4, 1);
        xfer(3, 1, 1, 2, 0, 1, 0);
        msg_end(0, 4);

        // spurious event in idle has no effect (R10)
        @(negedge clk); spur_req = 1;
        repeat (4) @(negedge clk); #3;
        chk(spur_seen == 1, "R10 spurious pulse", spur_seen, 1);
        chk(cnt_bytes == 3 && cs_n == 1, "R10 no effect", cnt_bytes, 3);

        // B: no-tx transfer then held chip select
        msg_begin(0, 1, 0, 100, 6, 3);
        xfer(2, 0, 1, 1, 0, 0, 0);
        xfer(1, 1, 0, 0, 0, 1, 0);
        msg_end(0, 2);

        // C: chip select dropped twice inside the message
        msg_begin(1, 1, 0, 1000, 7, 6);
        xfer(2, 1, 1, 3, 1, 0, 0);
        xfer(3, 1, 1, 0, 1, 0, 0);
        xfer(2, 1, 0, 4, 0, 1, 0);
        msg_end(0, 6);

        // D: collision on the first byte
        wcol_at = wr_idx;
        msg_begin(0, 0, 0, 2, 0, 0);
        xfer(2, 1, 1, 0, 0, 1, 0);
        msg_end(0, 2);
        wcol_at = -1;

        // E: mode fault on the second byte
        modf_at = wr_idx + 1;
        msg_begin(0, 1, 1, 4000, 7, 7);
        xfer(2, 1, 1, 5, 0, 1, 1);
        msg_end(1, 1);
        modf_at = -1;

        // F: recovery after a fault
        msg_begin(1, 0, 0, 16, 7, 0);
        xfer(4, 1, 1, 1, 0, 1, 0);
        msg_end(0, 3);

        #3;
        chk(cnt_bytes == CNT_W'(done_evts > 15 ? 15 : done_evts), "R11 bytes saturate",
            cnt_bytes, done_evts > 15 ? 15 : done_evts);
        chk(cnt_msgs == CNT_W'(5), "R11 message count", cnt_msgs, 5);
        chk(cnt_wcol == CNT_W'(1), "R11 collision count", cnt_wcol, 1);
        chk(cnt_modf == CNT_W'(1), "R11 fault count", cnt_modf, 1);
        chk(exp_wr_q.size() == 0 && exp_rx_q.size() == 0, "R4 all bytes seen",
            exp_wr_q.size() + exp_rx_q.size(), 0);
        chk(spur_seen == 1, "R10 no extra spurious", spur_seen, 1);
        finish_run();
    end
endmodule